// File: doc/BRIEF.md
# Power-Fail Page Save Sequencer

This block is an SPI master that, on a power-fail trigger, writes one page of critical status data into a serial flash memory that has on-chip page buffers. It works within the short time that a hold-up capacitor keeps the memory powered. The data to save sits in a local staging memory of one page, which the block reads through an address/data port. The block reads the staging memory asynchronously: the data for `stg_addr` must be valid in the same cycle. A target page number is captured when the sequence starts. That page number, followed by nine zero offset bits, forms the 24-bit byte address of the program command.

Without preload, the block sends three chip-select frames in turn. The first writes the page into the device's second buffer. The second commands a program of that buffer into main memory with no built-in erase. The third reads the status byte repeatedly until the device reports ready. With `preload` high, the buffer already holds the data, so the first frame is skipped and the save finishes sooner. Chip select is high while the block is idle and between frames.

When the sequence ends, `done` pulses for one cycle. The `err` output is high in the same cycle if the ready bit never came within the allowed number of status bytes.

Top module: `pfail_save_seq`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, spi_mosi is 0, and done and err are 0.
- R2: A sequence starts only on a 0-to-1 change of pfail while the block is idle. A pfail pulse during a running sequence is ignored. A pfail level held high past done does not start another sequence.
- R3: With preload at 0, the first frame is opcode 87h, then address bytes 00h 00h 00h, then the 264 staging bytes read at stg_addr 0 to 263 in ascending order, for 268 bytes in all.
- R4: The program frame is opcode 89h, then the 24-bit address {3'b000, page[11:0], 9'b0} sent most significant byte first, and nothing else (4 bytes).
- R5: The status frame is opcode D7h, then dummy bytes while status bytes are read. It ends after the first received byte whose bit 7 is 1.
- R6: The bus runs in SPI mode 0 with MSB first. spi_sck is low whenever spi_cs_n is high and when spi_cs_n falls. spi_mosi does not change while spi_sck is high. spi_miso is sampled on the rising edge. Every frame carries a whole number of bytes.
- R7: Between two frames of one sequence, spi_cs_n stays high for at least two SCK periods (4 x HALF_DIV clock cycles).
- R8: With preload at 1, only the program frame and the status frame are sent.
- R9: done is high for exactly one cycle per sequence, after the status frame has closed, with spi_cs_n high.
- R10: If max_polls status bytes have been read and none has bit 7 at 1, the status frame ends and err is 1 in the done cycle. Otherwise err is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfail | input | 1 | Power-fail trigger; acts on its rising edge while idle |
| preload | input | 1 | 1: device buffer already holds the page, so the fill frame is skipped |
| tgt_page | input | 12 | Target page number, captured at start |
| max_polls | input | 16 | Number of status bytes allowed before the timeout |
| stg_addr | output | 9 | Staging memory read address |
| stg_rdata | input | 8 | Staging memory read data, valid in the same cycle as stg_addr |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err | output | 1 | High with done when the ready bit was never seen |

## Verification
The hardest situations to reach from the ports are the timeout and the chain of status bytes that lead up to ready. Both depend on what the memory returns, byte by byte, inside one long chip-select frame. The bench contains a behavioural slave that decodes each frame bit by bit on SCK. After a D7h opcode it returns a chosen number of busy status bytes before the ready bit appears. Sweeping that count across the max_polls limit drives the sequencer to every way the status frame can end: ready on the first byte, ready after a few bytes, ready on the last allowed byte, and timeout. A second pfail pulse in the middle of each run, and one run with pfail held high, cover the cases where a trigger must be ignored.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    // Command opcodes understood by the memory device
    localparam logic [7:0] OP_BUF_FILL = 8'h87;
    localparam logic [7:0] OP_BUF_PROG = 8'h89;
    localparam logic [7:0] OP_STATUS   = 8'hD7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_XFER,
        ST_GAP,
        ST_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        FR_FILL,
        FR_PROG,
        FR_POLL
    } frame_e;
endpackage

// File: rtl/pfs_tick_gen.sv
module pfs_tick_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = $clog2(HALF_DIV + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!en) begin
            cnt_d = '0;
        end else if (cnt_q == CNT_W'(HALF_DIV - 1)) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pfs_byte_shift.sv
module pfs_byte_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       active,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       fin
);
    typedef struct packed {
        logic       act;
        logic       sck;
        logic [2:0] bitn;
        logic [7:0] sh;
        logic [7:0] rx;
        logic       fin;
    } sh_state_t;

    sh_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.fin = 1'b0;
        if (start) begin
            s_d.act  = 1'b1;
            s_d.sck  = 1'b0;
            s_d.bitn = '0;
            s_d.sh   = tx_byte;
        end else if (s_q.act && tick) begin
            if (!s_q.sck) begin
                // rising edge: capture the incoming bit
                s_d.sck = 1'b1;
                s_d.rx  = {s_q.rx[6:0], miso};
            end else begin
                // falling edge: present the next bit or close the byte
                s_d.sck = 1'b0;
                if (s_q.bitn == 3'd7) begin
                    s_d.act = 1'b0;
                    s_d.fin = 1'b1;
                end else begin
                    s_d.bitn = s_q.bitn + 3'd1;
                    s_d.sh   = {s_q.sh[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active  = s_q.act;
    assign sck     = s_q.sck;
    assign mosi    = s_q.act ? s_q.sh[7] : 1'b0;
    assign rx_byte = s_q.rx;
    assign fin     = s_q.fin;

    // R6: data line is held across the rising edge and the high phase
    p_mosi_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi));
    p_mosi_high_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/pfail_save_seq.sv
module pfail_save_seq #(
    parameter int HALF_DIV   = 2,
    parameter int PAGE_BYTES = 264,
    parameter int PAGE_W     = 12,
    parameter int POLL_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pfail,
    input  logic                  preload,
    input  logic [PAGE_W-1:0]     tgt_page,
    input  logic [POLL_W-1:0]     max_polls,
    output logic [$clog2(PAGE_BYTES)-1:0] stg_addr,
    input  logic [7:0]            stg_rdata,
    output logic                  spi_cs_n,
    output logic                  spi_sck,
    output logic                  spi_mosi,
    input  logic                  spi_miso,
    output logic                  done,
    output logic                  err
);
    import pfs_pkg::*;

    localparam int OFF_W     = $clog2(PAGE_BYTES);
    localparam int ADDR_W    = 24;
    localparam int HDR       = 1 + ADDR_W / 8;
    localparam int FILL_LAST = HDR + PAGE_BYTES - 1;
    localparam int IDX_W     = $clog2(FILL_LAST + 1);
    localparam int GAP_CYC   = 4 * HALF_DIV;
    localparam int GAP_W     = $clog2(GAP_CYC + 1);

    typedef struct packed {
        seq_state_e         st;
        frame_e             frm;
        logic [IDX_W-1:0]   idx;
        logic [GAP_W-1:0]   gcnt;
        logic [POLL_W-1:0]  polls;
        logic [ADDR_W-1:0]  addr;
        logic               err;
        logic               cs_n;
        logic               pf;
    } seq_t;

    seq_t q, d;

    logic       tick, sh_active, sh_fin, sh_start;
    logic [7:0] sh_rx, tx_byte;
    logic [ADDR_W-1:0] frame_addr;
    logic [POLL_W:0]   polls_next;

    pfs_tick_gen #(.HALF_DIV(HALF_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sh_active),
        .tick  (tick)
    );

    pfs_byte_shift shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (tx_byte),
        .tick    (tick),
        .miso    (spi_miso),
        .active  (sh_active),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .rx_byte (sh_rx),
        .fin     (sh_fin)
    );

    // Byte to transmit for the current frame position
    always_comb begin
        frame_addr = (q.frm == FR_FILL) ? '0 : q.addr;
        tx_byte    = 8'h00;
        if (q.frm == FR_POLL) begin
            tx_byte = (q.idx == '0) ? OP_STATUS : 8'h00;
        end else begin
            case (q.idx)
                IDX_W'(0): tx_byte = (q.frm == FR_FILL) ? OP_BUF_FILL : OP_BUF_PROG;
                IDX_W'(1): tx_byte = frame_addr[23:16];
                IDX_W'(2): tx_byte = frame_addr[15:8];
                IDX_W'(3): tx_byte = frame_addr[7:0];
                default:   tx_byte = stg_rdata;
            endcase
        end
    end

    assign stg_addr = (q.frm == FR_FILL && q.idx >= IDX_W'(HDR))
                    ? OFF_W'(q.idx - IDX_W'(HDR)) : '0;
    assign sh_start   = (q.st == ST_LOAD);
    assign polls_next = {1'b0, q.polls} + 1'b1;

    always_comb begin
        d    = q;
        d.pf = pfail;
        case (q.st)
            ST_IDLE: begin
                if (pfail && !q.pf) begin
                    d.frm   = preload ? FR_PROG : FR_FILL;
                    d.idx   = '0;
                    d.polls = '0;
                    d.err   = 1'b0;
                    d.addr  = {{(ADDR_W-PAGE_W-OFF_W){1'b0}}, tgt_page, {OFF_W{1'b0}}};
                    d.st    = ST_LOAD;
                end
            end
            ST_LOAD: begin
                d.cs_n = 1'b0;
                d.st   = ST_XFER;
            end
            ST_XFER: begin
                if (sh_fin) begin
                    if (q.frm == FR_POLL) begin
                        if (q.idx == '0) begin
                            d.idx = IDX_W'(1);
                            d.st  = ST_LOAD;
                        end else if (sh_rx[7]) begin
                            d.cs_n = 1'b1;
                            d.st   = ST_FIN;
                        end else if (polls_next >= {1'b0, max_polls}) begin
                            d.err  = 1'b1;
                            d.cs_n = 1'b1;
                            d.st   = ST_FIN;
                        end else begin
                            d.polls = polls_next[POLL_W-1:0];
                            d.st    = ST_LOAD;
                        end
                    end else if (q.idx == ((q.frm == FR_FILL) ? IDX_W'(FILL_LAST)
                                                                : IDX_W'(HDR - 1))) begin
                        d.cs_n = 1'b1;
                        d.gcnt = '0;
                        d.st   = ST_GAP;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.st  = ST_LOAD;
                    end
                end
            end
            ST_GAP: begin
                if (q.gcnt == GAP_W'(GAP_CYC - 1)) begin
                    d.idx = '0;
                    d.frm = (q.frm == FR_FILL) ? FR_PROG : FR_POLL;
                    d.st  = ST_LOAD;
                end else begin
                    d.gcnt = q.gcnt + 1'b1;
                end
            end
            ST_FIN:  d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.frm  <= FR_FILL;
            q.cs_n <= 1'b1;
            q.pf   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign spi_cs_n = q.cs_n;
    assign done     = (q.st == ST_FIN);
    assign err      = done && q.err;

    // R6: clock idles low outside a frame (select from sequencer, clock from shifter)
    p_sck_low_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    // R9: completion pulse is single-cycle and seen with the device deselected
    p_done_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: error flag only qualifies a completion
    p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    // R3: staging reads stay inside the page
    p_stg_in_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stg_addr < OFF_W'(PAGE_BYTES));
    // R7: a released select stays high for at least the next cycle
    p_cs_release_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n);
endmodule

// File: tb/pfail_save_seq_tb_top.sv
module pfail_save_seq_tb_top;
    localparam int HALF = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfail = 1'b0;
    logic        preload = 1'b0;
    logic [11:0] tgt_page = '0;
    logic [15:0] max_polls = 16'd4;
    logic [8:0]  stg_addr;
    logic [7:0]  stg_rdata;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;
    logic        done, err;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    // staging memory: computed pattern, asynchronous read
    logic [7:0] seed = 8'h11;
    assign stg_rdata = 8'(stg_addr * 37) + seed;

    pfail_save_seq #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .pfail(pfail), .preload(preload),
        .tgt_page(tgt_page), .max_polls(max_polls),
        .stg_addr(stg_addr), .stg_rdata(stg_rdata),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .done(done), .err(err)
    );

    // ---------------- behavioural memory slave ----------------
    logic [7:0] rxb [0:299];
    logic [7:0] cur = '0;
    int  nbits = 0;
    bit  in_frame = 0;
    int  busy_n = 0;
    int  nfr = 0;
    logic [7:0]  fr_op   [0:7];
    logic [23:0] fr_addr [0:7];
    int  fr_len [0:7];
    int  fr_bad [0:7];
    int  gap = 0;
    int  gapbad = 0;
    int  modebad = 0;
    int  done_cnt = 0;
    bit  last_err = 0;

    always @(negedge spi_cs_n) begin
        if (spi_sck) modebad++;
        if (nfr > 0 && gap < 4 * HALF) gapbad++;
        nbits = 0; in_frame = 1; spi_miso = 1'b0;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            cur = {cur[6:0], spi_mosi};
            nbits++;
            if (nbits % 8 == 0 && nbits / 8 <= 300) rxb[nbits/8-1] = cur;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && nbits >= 8 && rxb[0] == 8'hD7) begin
            int s, b;
            s = (nbits - 8) / 8;
            b = 7 - ((nbits - 8) % 8);
            spi_miso = (s >= busy_n && b == 7);
        end
    end

    always @(posedge spi_cs_n) begin
        if (in_frame) begin
            int bad;
            in_frame = 0;
            gap = 0;
            if (nbits % 8 != 0) modebad++;
            bad = 0;
            if (nfr < 8) begin
                fr_op[nfr]   = rxb[0];
                fr_addr[nfr] = {rxb[1], rxb[2], rxb[3]};
                fr_len[nfr]  = nbits / 8;
                if (rxb[0] == 8'h87)
                    for (int i = 4; i < nbits / 8; i++)
                        if (rxb[i] != 8'((i - 4) * 37) + seed) bad++;
                fr_bad[nfr] = bad;
            end
            nfr++;
        end
    end

    always @(negedge clk) begin
        if (rst_n && spi_cs_n) gap++;
        if (done) begin done_cnt++; last_err = err; end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input bit pre, input int page, input int busy,
                           input int maxp, input bit hold);
        int wd, exp_fr, k, exp_poll;
        bit exp_err;
        preload = pre; tgt_page = 12'(page); max_polls = 16'(maxp);
        busy_n = busy; nfr = 0; done_cnt = 0; gapbad = 0; modebad = 0;
        @(negedge clk) pfail = 1'b1;
        repeat (3) @(negedge clk);
        if (!hold) pfail = 1'b0;
        repeat (40) @(negedge clk);
        if (!hold) begin pfail = 1'b1; @(negedge clk); pfail = 1'b0; end // R2 ignored pulse
        wd = 0;
        while (done_cnt == 0 && wd < 20000) begin @(negedge clk); wd++; end
        check(wd < 20000, "R9 watchdog", wd, 20000);
        repeat (80) @(negedge clk);

        exp_fr   = pre ? 2 : 3;
        exp_err  = (busy >= maxp);
        exp_poll = 1 + (exp_err ? maxp : busy + 1);
        check(done_cnt == 1, "R9 done pulses", done_cnt, 1);
        check(nfr == exp_fr, pre ? "R8 frame count" : "R2 frame count", nfr, exp_fr);
        k = 0;
        if (!pre) begin
            check(fr_op[0] == 8'h87, "R3 fill opcode", fr_op[0], 8'h87);
            check(fr_addr[0] == 24'h0, "R3 fill address", fr_addr[0], 0);
            check(fr_len[0] == 268, "R3 fill length", fr_len[0], 268);
            check(fr_bad[0] == 0, "R3 fill data", fr_bad[0], 0);
            k = 1;
        end
        check(fr_op[k] == 8'h89, "R4 program opcode", fr_op[k], 8'h89);
        check(fr_addr[k] == 24'(page << 9), "R4 program address", fr_addr[k], page << 9);
        check(fr_len[k] == 4, "R4 program length", fr_len[k], 4);
        check(fr_op[k+1] == 8'hD7, "R5 status opcode", fr_op[k+1], 8'hD7);
        check(fr_len[k+1] == exp_poll, "R5 status bytes", fr_len[k+1], exp_poll);
        check(last_err == exp_err, "R10 error flag", last_err, exp_err);
        check(gapbad == 0, "R7 deselect gap", gapbad, 0);
        check(modebad == 0, "R6 mode 0 framing", modebad, 0);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R9 idle after done", spi_cs_n, 1);
        pfail = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        int pages [3] = '{12'hFFF, 12'h000, 12'hA5C};
        int busys [4] = '{0, 2, 3, 5};
        repeat (3) @(negedge clk);
        // R1: reset values
        check(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
        check(spi_mosi == 1'b0, "R1 mosi", spi_mosi, 0);
        check(done == 1'b0 && err == 1'b0, "R1 done/err", done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int p = 0; p < 2; p++)
            for (int g = 0; g < 3; g++)
                for (int b = 0; b < 4; b++) begin
                    if (p == 0 && b == 2) continue;
                    seed = 8'(g * 53 + b + 1);
                    run_seq(p[0], pages[g], busys[b], 4, 1'b0);
                end
        // single allowed status byte: ready at once, then timeout
        run_seq(1'b1, 12'h123, 0, 1, 1'b0);
        run_seq(1'b1, 12'h123, 1, 1, 1'b0);
        // R2: level held high through completion must not restart
        run_seq(1'b0, 12'hFFF, 1, 4, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule